// File: doc/BRIEF.md
# Truncating Single-Precision Floating-Point Adder

This block adds two binary floating-point values in the standard 32-bit layout: a sign bit on top, then an 8-bit biased exponent, then 23 fraction bits. The result comes back in the same layout. The field widths are parameters, so the same logic also builds narrow formats, for example a 4-bit exponent with a 3-bit fraction.

The adder first decides which operand has the larger magnitude and restores the hidden leading one on both mantissas. It then moves the smaller mantissa right by the exponent gap. Depending on the signs, it adds the two mantissas or subtracts the smaller from the larger. The raw result is renormalised and packed again.

Operands are assumed normalised, and the result is assumed to stay inside the normal exponent range. Bits pushed out during alignment or renormalisation are discarded, which truncates the result. There is no handling of zero, denormal, infinite or not-a-number inputs.

The datapath has an output register and, when `PIPE_MID` is 1, a second register between the add and the renormalise step. A valid flag travels alongside the data through each register.

Top module: `fpadd_sp`

## Requirements
- R1: The operand and result word is laid out, from the most significant bit down, as one sign bit, an `EXP_W`-bit biased exponent, and a `MAN_W`-bit fraction. Each normalised operand carries an implicit leading one above its fraction. With the defaults, 1.0 is 0x3F800000 and 1.0 + 1.0 gives 0x40000000.
- R2: When both signs are equal, the magnitudes are added. The result carries that common sign, and its exponent equals the larger input exponent or exceeds it by one (for example, -2.0 + -3.0 = 0xC0A00000).
- R3: When the mantissa sum overflows into the bit above the hidden one, the sum is shifted right by one, its lowest bit is dropped, and the exponent rises by one (0x3F800001 + 0x3F800000 = 0x40000000).
- R4: The mantissa of the smaller-magnitude operand is shifted right by the exponent difference, and bits shifted out are lost. A difference above `MAN_W` makes it vanish entirely (1.0 + 2^-30 = 1.0; 2^24 + 1.0 = 0x4B800000). The larger-magnitude operand is the one whose sign-less word is greater, with ties going to `op_a`.
- R5: When the signs differ, the aligned smaller magnitude is subtracted from the larger, and a nonzero result takes the sign of the larger-magnitude operand (10.0 + -3.0 = 7.0; -10.0 + 3.0 = -7.0).
- R6: After a subtraction, the mantissa is shifted left until its leading one sits in the hidden position, and the exponent is lowered by the shift count. The count can be as large as `MAN_W` (1.0 + -0x3F7FFFFF = 0x34000000).
- R7: Operands of equal magnitude and opposite sign give all-zero bits, which is positive zero.
- R8: The result does not depend on operand order: a + b equals b + a.
- R9: `out_valid` is high exactly 1 + `PIPE_MID` cycles after the cycle in which `in_valid` was sampled high, and low otherwise. `sum` holds the matching result while `out_valid` is high.
- R10: While `rst_n` is low, `out_valid` and `sum` are zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be added this cycle |
| op_a | input | 1+EXP_W+MAN_W | First operand |
| op_b | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | `sum` carries a result |
| sum | output | 1+EXP_W+MAN_W | Truncated sum |

## Verification
The bound checker follows the inputs through its own delay line. On every cycle it checks the valid latency, the positive-zero encoding, the sign rules, and the exponent window that same-sign addition and cancelling subtraction must stay inside. The exact fraction bits are not checked there: truncation at alignment, the lost bit after a carry, and the exact left-shift amount show only in the bench. The bench compares every result against arithmetic computed separately, on directed cases and on an exhaustive sweep of the narrow format. Operand-order independence and reset dominance are likewise shown by scenarios only.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;

   // Effective mantissa operation once the signs are compared
   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } eff_op_e;

endpackage

// File: rtl/fpa_align.sv
`timescale 1ns/1ps
// Orders the operands by magnitude and aligns the smaller mantissa.
module fpa_align #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op_a,
   input  logic [EXP_W+MAN_W:0] op_b,
   output logic                 big_sign,
   output logic [EXP_W-1:0]     big_exp,
   output logic [MAN_W:0]       big_mant,
   output logic [MAN_W:0]       small_mant,
   output fpadd_pkg::eff_op_e   eff_op
);
   localparam int W = 1 + EXP_W + MAN_W;

   logic             a_ge_b;
   logic [W-1:0]     big_w;
   logic [W-1:0]     small_w;
   logic [EXP_W-1:0] small_exp;
   logic [EXP_W-1:0] exp_gap;
   logic [MAN_W:0]   small_raw;

   // Sign-less words compare like magnitudes for normalised values
   assign a_ge_b    = op_a[W-2:0] >= op_b[W-2:0];
   assign big_w     = a_ge_b ? op_a : op_b;
   assign small_w   = a_ge_b ? op_b : op_a;

   assign big_sign  = big_w[W-1];
   assign big_exp   = big_w[MAN_W +: EXP_W];
   assign small_exp = small_w[MAN_W +: EXP_W];
   assign big_mant  = {1'b1, big_w[MAN_W-1:0]};
   assign small_raw = {1'b1, small_w[MAN_W-1:0]};
   assign exp_gap   = big_exp - small_exp;

   // A gap past the mantissa width leaves nothing of the small operand
   assign small_mant = (int'(exp_gap) > MAN_W) ? '0 : (small_raw >> exp_gap);

   assign eff_op = (big_w[W-1] != small_w[W-1]) ? fpadd_pkg::OP_SUB
                                                 : fpadd_pkg::OP_ADD;
endmodule

// File: rtl/fpa_addsub.sv
`timescale 1ns/1ps
// Mantissa adder/subtractor with one carry bit above the hidden one.
module fpa_addsub #(
   parameter int MAN_W = 23
) (
   input  fpadd_pkg::eff_op_e eff_op,
   input  logic [MAN_W:0]     big_mant,
   input  logic [MAN_W:0]     small_mant,
   output logic [MAN_W+1:0]   raw
);
   logic [MAN_W+1:0] big_x;
   logic [MAN_W+1:0] small_x;

   assign big_x   = {1'b0, big_mant};
   assign small_x = {1'b0, small_mant};

   // big >= small, so a subtraction never borrows
   always_comb begin
      if (eff_op == fpadd_pkg::OP_SUB) raw = big_x - small_x;
      else                             raw = big_x + small_x;
   end
endmodule

// File: rtl/fpa_norm.sv
`timescale 1ns/1ps
// Renormalises the raw mantissa and packs sign, exponent and fraction.
module fpa_norm #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 big_sign,
   input  logic [EXP_W-1:0]     big_exp,
   input  logic [MAN_W+1:0]     raw,
   output logic [EXP_W+MAN_W:0] result
);
   localparam int LZ_W = $clog2(MAN_W + 2);

   logic            carry;
   logic            nonzero;
   logic [LZ_W-1:0] lz;
   logic [MAN_W:0]  norm_mant;

   assign carry = raw[MAN_W+1];

   // Priority search for the leading one below the carry bit
   always_comb begin
      lz      = '0;
      nonzero = 1'b0;
      for (int i = MAN_W; i >= 0; i--) begin
         if (!nonzero && raw[i]) begin
            lz      = LZ_W'(MAN_W - i);
            nonzero = 1'b1;
         end
      end
   end

   assign norm_mant = raw[MAN_W:0] << lz;

   always_comb begin
      if (carry) begin
         result = {big_sign, big_exp + 1'b1, raw[MAN_W:1]};
      end else if (!nonzero) begin
         result = '0;
      end else begin
         result = {big_sign, big_exp - EXP_W'(lz), norm_mant[MAN_W-1:0]};
      end
   end
endmodule

// File: rtl/fpadd_sp.sv
`timescale 1ns/1ps
// Truncating floating-point adder, optional register before renormalise.
module fpadd_sp #(
   parameter int EXP_W    = 8,
   parameter int MAN_W    = 23,
   parameter int PIPE_MID = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [EXP_W+MAN_W:0] op_a,
   input  logic [EXP_W+MAN_W:0] op_b,
   output logic                 out_valid,
   output logic [EXP_W+MAN_W:0] sum
);
   localparam int W    = 1 + EXP_W + MAN_W;
   localparam int LZ_W = $clog2(MAN_W + 2);

   // Elaboration-time parameter checks
   if (EXP_W < 3) begin : g_bad_exp
      $error("fpadd_sp: EXP_W must be at least 3");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("fpadd_sp: MAN_W must be at least 2");
   end
   if (PIPE_MID != 0 && PIPE_MID != 1) begin : g_bad_pipe
      $error("fpadd_sp: PIPE_MID must be 0 or 1");
   end
   if (LZ_W > EXP_W) begin : g_bad_lz
      $error("fpadd_sp: exponent too narrow for the shift count");
   end

   // Stage 1: order, align, add/subtract
   logic                 s1_sign;
   logic [EXP_W-1:0]     s1_exp;
   logic [MAN_W:0]       s1_big;
   logic [MAN_W:0]       s1_small;
   logic [MAN_W+1:0]     s1_raw;
   fpadd_pkg::eff_op_e   s1_op;

   fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
      .op_a       (op_a),
      .op_b       (op_b),
      .big_sign   (s1_sign),
      .big_exp    (s1_exp),
      .big_mant   (s1_big),
      .small_mant (s1_small),
      .eff_op     (s1_op)
   );

   fpa_addsub #(.MAN_W(MAN_W)) u_addsub (
      .eff_op     (s1_op),
      .big_mant   (s1_big),
      .small_mant (s1_small),
      .raw        (s1_raw)
   );

   // Boundary between add and renormalise
   logic             m_valid;
   logic             m_sign;
   logic [EXP_W-1:0] m_exp;
   logic [MAN_W+1:0] m_raw;

   if (PIPE_MID == 1) begin : g_mid_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) m_valid <= 1'b0;
         else        m_valid <= in_valid;
      end
      always_ff @(posedge clk) begin
         if (in_valid) begin
            m_sign <= s1_sign;
            m_exp  <= s1_exp;
            m_raw  <= s1_raw;
         end
      end
   end else begin : g_mid_comb
      assign m_valid = in_valid;
      assign m_sign  = s1_sign;
      assign m_exp   = s1_exp;
      assign m_raw   = s1_raw;
   end

   // Stage 2: renormalise, pack, register
   logic [W-1:0] packed_res;

   fpa_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
      .big_sign (m_sign),
      .big_exp  (m_exp),
      .raw      (m_raw),
      .result   (packed_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         sum       <= '0;
      end else begin
         out_valid <= m_valid;
         if (m_valid) sum <= packed_res;
      end
   end
endmodule

// File: rtl/fpadd_sp_chk.sv
`timescale 1ns/1ps
// Property checker bound to fpadd_sp.
module fpadd_sp_chk #(
   parameter int EXP_W    = 8,
   parameter int MAN_W    = 23,
   parameter int PIPE_MID = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [EXP_W+MAN_W:0] op_a,
   input logic [EXP_W+MAN_W:0] op_b,
   input logic                 out_valid,
   input logic [EXP_W+MAN_W:0] sum
);
   localparam int W   = 1 + EXP_W + MAN_W;
   localparam int LAT = 1 + PIPE_MID;

   logic         v_h [LAT];
   logic [W-1:0] a_h [LAT];
   logic [W-1:0] b_h [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) v_h[i] <= 1'b0;
      end else begin
         v_h[0] <= in_valid;
         for (int i = 1; i < LAT; i++) v_h[i] <= v_h[i-1];
      end
   end

   always_ff @(posedge clk) begin
      a_h[0] <= op_a;
      b_h[0] <= op_b;
      for (int i = 1; i < LAT; i++) begin
         a_h[i] <= a_h[i-1];
         b_h[i] <= b_h[i-1];
      end
   end

   logic [W-1:0]     oa, ob;
   logic             sa, sb, a_big, bsign, res_zero;
   logic [EXP_W-1:0] bexp, rexp;
   logic [EXP_W:0]   bexp_p1;

   assign oa       = a_h[LAT-1];
   assign ob       = b_h[LAT-1];
   assign sa       = oa[W-1];
   assign sb       = ob[W-1];
   assign a_big    = oa[W-2:0] >= ob[W-2:0];
   assign bsign    = a_big ? sa : sb;
   assign bexp     = a_big ? oa[MAN_W +: EXP_W] : ob[MAN_W +: EXP_W];
   assign bexp_p1  = {1'b0, bexp} + 1'b1;
   assign rexp     = sum[MAN_W +: EXP_W];
   assign res_zero = (sum[W-2:0] == '0);

   // R9
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_h[LAT-1]);

   // R7
   zero_plus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && res_zero |-> !sum[W-1]);

   // R2
   same_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (sa == sb) |->
         (sum[W-1] == sa) && ((rexp == bexp) || ({1'b0, rexp} == bexp_p1)));

   // R5
   diff_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (sa != sb) && !res_zero |-> sum[W-1] == bsign);

   // R6
   sub_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (sa != sb) && !res_zero |->
         (rexp <= bexp) && (({1'b0, rexp} + (EXP_W+1)'(MAN_W)) >= {1'b0, bexp}));
endmodule

bind fpadd_sp fpadd_sp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .PIPE_MID(PIPE_MID)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .out_valid (out_valid),
   .sum       (sum)
);

// File: tb/tb_fpadd_sp.sv
`timescale 1ns/1ps
module tb_fpadd_sp;
   localparam int LAT_BIG = 2;
   localparam int SM_CODES = 224;           // 2 signs x 14 exponents x 8 fractions
   localparam int SM_TOT   = SM_CODES * SM_CODES;
   localparam int BIG_N    = 3000;

   logic clk = 1'b0;
   logic rst_n;
   always #4 clk = ~clk;                    // 125 MHz

   logic [31:0] a_big, b_big, s_big;
   logic        v_big, ov_big;
   logic [7:0]  a_sm, b_sm, s_sm;
   logic        v_sm, ov_sm;

   fpadd_sp dut (
      .clk(clk), .rst_n(rst_n), .in_valid(v_big), .op_a(a_big), .op_b(b_big),
      .out_valid(ov_big), .sum(s_big)
   );

   fpadd_sp #(.EXP_W(4), .MAN_W(3), .PIPE_MID(0)) dut_small (
      .clk(clk), .rst_n(rst_n), .in_valid(v_sm), .op_a(a_sm), .op_b(b_sm),
      .out_valid(ov_sm), .sum(s_sm)
   );

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Arithmetic reference built from the requirements; -1 means out of range
   function automatic longint fp_model(int ew, int mw, longint a, longint b);
      longint fm, em, magm, sl, el, ml, es, ms, d, al, r, e;
      fm   = (64'sd1 << mw) - 1;
      em   = (64'sd1 << ew) - 1;
      magm = (64'sd1 << (ew + mw)) - 1;
      if ((a & magm) >= (b & magm)) begin
         sl = (a >> (ew + mw)) & 1; el = (a >> mw) & em; ml = (a & fm) | (64'sd1 << mw);
         es = (b >> mw) & em; ms = (b & fm) | (64'sd1 << mw);
         if ((((b >> (ew + mw)) & 1)) == sl) d = 0; else d = 1;
      end else begin
         sl = (b >> (ew + mw)) & 1; el = (b >> mw) & em; ml = (b & fm) | (64'sd1 << mw);
         es = (a >> mw) & em; ms = (a & fm) | (64'sd1 << mw);
         if ((((a >> (ew + mw)) & 1)) == sl) d = 0; else d = 1;
      end
      r = d;                                 // r: 1 when the signs differ
      d = el - es;
      al = (d > mw) ? 0 : (ms >> d);
      e = el;
      if (r == 0) begin
         r = ml + al;
         if ((r >> (mw + 1)) != 0) begin r = r >> 1; e = e + 1; end
      end else begin
         r = ml - al;
         if (r == 0) return 0;
         while (((r >> mw) & 1) == 0) begin r = r << 1; e = e - 1; end
      end
      if (e < 1 || e > em - 1) return -1;
      return (sl << (ew + mw)) | (e << mw) | (r & fm);
   endfunction

   function automatic string tag_of(int ew, int mw, longint a, longint b, longint res);
      if (((a >> (ew + mw)) & 1) == ((b >> (ew + mw)) & 1)) return "R2";
      if (res == 0) return "R7";
      return "R5";
   endfunction

   logic [31:0] rng = 32'h1234_5678;
   function automatic logic [31:0] next_rng();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   task automatic dir_big(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] expv, input string tag);
      @(negedge clk); a_big = a; b_big = b; v_big = 1'b1;
      @(negedge clk); v_big = 1'b0;
      chk("R9 early", {63'b0, ov_big}, 64'd0);
      @(negedge clk);
      chk("R9", {63'b0, ov_big}, 64'd1);
      chk(tag, {32'b0, s_big}, {32'b0, expv});
   endtask

   logic [31:0] ring   [8];
   logic        ring_v [8];
   string       ring_t [8];

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0;
      // Inputs active during reset must not reach the outputs (R10)
      v_big = 1'b1; a_big = 32'h3F80_0000; b_big = 32'h4000_0000;
      v_sm  = 1'b1; a_sm  = 8'h38;         b_sm  = 8'h40;
      repeat (3) @(negedge clk);
      chk("R10 valid", {63'b0, ov_big}, 64'd0);
      chk("R10 sum",   {32'b0, s_big},  64'd0);
      chk("R10 small valid", {63'b0, ov_sm}, 64'd0);
      chk("R10 small sum",   {56'b0, s_sm},  64'd0);
      v_big = 1'b0; v_sm = 1'b0;
      @(negedge clk); rst_n = 1'b1;

      // Directed cases on the default format
      dir_big(32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, "R1");
      dir_big(32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, "R2");
      dir_big(32'hC000_0000, 32'hC040_0000, 32'hC0A0_0000, "R2 neg");
      dir_big(32'h3FC0_0000, 32'h3FC0_0000, 32'h4040_0000, "R3");
      dir_big(32'h3F80_0001, 32'h3F80_0000, 32'h4000_0000, "R3 drop");
      dir_big(32'h3F80_0000, 32'h3E80_0000, 32'h3FA0_0000, "R4 shift");
      dir_big(32'h3F80_0000, 32'h3080_0000, 32'h3F80_0000, "R4 vanish");
      dir_big(32'h4B80_0000, 32'h3F80_0000, 32'h4B80_0000, "R4 trunc");
      dir_big(32'h4120_0000, 32'hC040_0000, 32'h40E0_0000, "R5");
      dir_big(32'hC120_0000, 32'h4040_0000, 32'hC0E0_0000, "R5 neg");
      dir_big(32'hC040_0000, 32'h4120_0000, 32'h40E0_0000, "R8");
      dir_big(32'h4040_0000, 32'hC000_0000, 32'h3F80_0000, "R6");
      dir_big(32'h3F80_0000, 32'hBF7F_FFFF, 32'h3400_0000, "R6 deep");
      dir_big(32'h3FC0_0000, 32'hBFC0_0000, 32'h0000_0000, "R7");
      dir_big(32'hBFC0_0000, 32'h3FC0_0000, 32'h0000_0000, "R7 swap");

      // Streamed pseudo-random sweep on the default format, with bubbles
      for (int i = 0; i < BIG_N + LAT_BIG; i++) begin
         @(negedge clk);
         if (i >= LAT_BIG) begin
            chk("R9 stream", {63'b0, ov_big}, {63'b0, ring_v[(i - LAT_BIG) % 8]});
            if (ring_v[(i - LAT_BIG) % 8])
               chk(ring_t[(i - LAT_BIG) % 8], {32'b0, s_big}, {32'b0, ring[(i - LAT_BIG) % 8]});
         end
         if (i < BIG_N && (i % 9) != 8) begin
            logic [31:0] r1, r2, r3, ra, rb;
            logic [7:0]  ea, eb;
            r1 = next_rng(); r2 = next_rng(); r3 = next_rng();
            ea = 8'(64 + (r1 % 127));
            if (r3[0]) eb = ea - 8'(r3[7:1] % 8);
            else       eb = 8'(64 + (r3 % 127));
            ra = {r1[31], ea, r2[22:0]};
            rb = {r3[31], eb, r1[22:0]};
            if (r3[11:8] == 4'd0) rb = ra ^ 32'h8000_0000;
            a_big = ra; b_big = rb; v_big = 1'b1;
            ring[i % 8]   = 32'(fp_model(8, 23, longint'(ra), longint'(rb)));
            ring_v[i % 8] = 1'b1;
            ring_t[i % 8] = tag_of(8, 23, longint'(ra), longint'(rb), longint'(ring[i % 8]));
         end else begin
            v_big = 1'b0;
            ring_v[i % 8] = 1'b0;
         end
      end

      // Exhaustive sweep of the narrow format (both orders cover R8)
      for (int i = 0; i <= SM_TOT; i++) begin
         @(negedge clk);
         if (i >= 1) begin
            chk("R9 small", {63'b0, ov_sm}, {63'b0, ring_v[(i - 1) % 8]});
            if (ring_v[(i - 1) % 8])
               chk(ring_t[(i - 1) % 8], {56'b0, s_sm}, {56'b0, ring[(i - 1) % 8][7:0]});
         end
         if (i < SM_TOT) begin
            int ia, ib;
            logic [7:0] ca, cb;
            longint m;
            ia = i / SM_CODES; ib = i % SM_CODES;
            ca = {1'(ia / 112), 4'(1 + (ia % 112) / 8), 3'(ia % 8)};
            cb = {1'(ib / 112), 4'(1 + (ib % 112) / 8), 3'(ib % 8)};
            m  = fp_model(4, 3, longint'(ca), longint'(cb));
            a_sm = ca; b_sm = cb;
            if (m < 0) begin
               v_sm = 1'b0; ring_v[i % 8] = 1'b0;
            end else begin
               v_sm = 1'b1; ring_v[i % 8] = 1'b1;
               ring[i % 8]   = 32'(m);
               ring_t[i % 8] = tag_of(4, 3, longint'(ca), longint'(cb), m);
            end
         end else begin
            v_sm = 1'b0;
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule